// File: doc/BRIEF.md
# I2C Bit-Rate Divider

This block derives the bit timing of an I2C engine from the system clock. A 7-bit rate value is stored in a register. It is split into a linear divisor M and an exponent N. Two cascaded counters turn these into one sample phase of (M+1)·2^(N+1) clock cycles. Ten sample phases make one SCL period, so the SCL frequency is the system clock divided by 10·(M+1)·2^(N+1).

The engine reads a one-cycle phase tick, the current phase number and an SCL level. It also gets single-cycle pulses that mark where SCL rises and where it falls. A rate value written while the engine runs is held back until the current SCL period ends. A build parameter selects a variant in which the exponent stage divides by 2^N instead of 2^(N+1).

Top module: `scl_rate_div`

## Requirements
- R1: After a synchronous reset, `baud_rd` reads 0x44 (M=8, N=4) and `bit_tick`, `scl_high`, `scl_rise`, `scl_fall` and `phase_idx` are all zero.
- R2: A write (`baud_wr` high for one cycle) makes `baud_rd` show `baud_wdata` in the following cycle. M sits in bits 6:3 and N in bits 2:0.
- R3: In the default mode, `bit_tick` pulses for one cycle every (M+1)·2^(N+1) clock cycles. The first pulse comes exactly that many cycles after `eng_en` is sampled high.
- R4: Each tick advances `phase_idx` through 1,2,…,9,0, giving ten ticks per SCL period. Between ticks `phase_idx` does not change.
- R5: `scl_high` is 0 in phases 0–4 and 1 in phases 5–9. `scl_rise` pulses together with the tick that enters phase 5, and `scl_fall` with the tick that enters phase 0.
- R6: A rate value written while enabled does not change the tick spacing until the tick that enters phase 0. From then on, the new spacing applies.
- R7: While `eng_en` is low, no tick or edge pulse is produced and `phase_idx` and `scl_high` stay 0. On re-enable, the counting restarts from zero.
- R8: A rate value written while disabled applies to the very first phase after enabling.
- R9: With parameter `EXP_PLUS_ONE` = 0, the phase length is (M+1)·2^N cycles.
- R10: The extreme values divide correctly: 0x00 gives 2 cycles per phase (1 in the variant), and 0x7F gives 4096 (2048 in the variant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_en | input | 1 | Engine enable; low holds all counters at zero |
| baud_wr | input | 1 | Write strobe for the rate register |
| baud_wdata | input | 7 | New rate value {M[3:0], N[2:0]} |
| baud_rd | output | 7 | Rate register contents |
| bit_tick | output | 1 | One-cycle pulse per sample phase |
| phase_idx | output | 4 | Current sample phase, 0 to 9 |
| scl_high | output | 1 | SCL level for the current phase |
| scl_rise | output | 1 | Pulse on entry to phase 5 |
| scl_fall | output | 1 | Pulse on entry to phase 0 |

## Verification
The bench targets the divider extremes. With M=0 and N=0, a design that loses a count in either stage would produce single-cycle phases. With M=15 and N=7, an exponent stage that is one bit too narrow would wrap early and shorten the phase. A rate change is written a few phases into a period, and the bench checks that the old spacing holds until phase 0. A design that loads the value at once would produce a mixed-length SCL period. Enable is also toggled: a design that keeps stale prescaler counts while disabled would deliver its first tick early after re-enable. The exponent variant is checked against the 2^N formula, where an off-by-one would double or halve every phase.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int M_W    = 4;
  localparam int N_W    = 3;
  localparam int BAUD_W = M_W + N_W;

  // M occupies the upper bits, N the lower bits of the rate value
  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } baud_t;
endpackage

// File: rtl/scl_baud_reg.sv
module scl_baud_reg
  import scl_div_pkg::*;
#(
  parameter logic [BAUD_W-1:0] RESET_BAUD = 7'h44
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  wr_en,
  input  baud_t wr_data,
  input  logic  period_end,
  output baud_t baud_q,
  output baud_t act_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q <= baud_t'(RESET_BAUD);
      act_q  <= baud_t'(RESET_BAUD);
    end else begin
      if (wr_en)
        baud_q <= wr_data;
      // the divisor in use changes only when idle or on a period boundary
      if (!en || period_end)
        act_q <= wr_en ? wr_data : baud_q;
    end
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_div_pkg::*;
#(
  parameter bit EXP_PLUS_ONE = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  baud_t act,
  output logic  wrap
);
  localparam int EXP_CW = 1 << N_W;

  logic [M_W-1:0]    lin_cnt;
  logic [EXP_CW-1:0] exp_cnt;
  logic [N_W:0]      shamt;
  logic [EXP_CW-1:0] exp_lim;
  logic              lin_done;
  logic              exp_done;

  generate
    if (EXP_PLUS_ONE) begin : g_pow_plus1
      assign shamt = {1'b0, act.n} + (N_W+1)'(1);
    end else begin : g_pow_plain
      assign shamt = {1'b0, act.n};
    end
  endgenerate

  // 2^shamt - 1; a full-width shift wraps to zero and gives all ones
  assign exp_lim  = (EXP_CW'(1) << shamt) - EXP_CW'(1);
  assign lin_done = (lin_cnt == act.m);
  assign exp_done = (exp_cnt == exp_lim);
  assign wrap     = en && lin_done && exp_done;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lin_cnt <= '0;
      exp_cnt <= '0;
    end else if (lin_done) begin
      lin_cnt <= '0;
      exp_cnt <= exp_done ? '0 : exp_cnt + EXP_CW'(1);
    end else begin
      lin_cnt <= lin_cnt + M_W'(1);
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int PHASES = 10,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            wrap,
  output logic            period_end,
  output logic            tick_q,
  output logic [PH_W-1:0] phase_q,
  output logic            scl_hi_q,
  output logic            rise_q,
  output logic            fall_q
);
  localparam int HALF = PHASES / 2;

  logic            last_phase;
  logic [PH_W-1:0] phase_nxt;

  assign last_phase = (phase_q == PH_W'(PHASES - 1));
  assign period_end = wrap && last_phase;
  assign phase_nxt  = last_phase ? '0 : phase_q + PH_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q  <= '0;
      tick_q   <= 1'b0;
      scl_hi_q <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else begin
      tick_q <= wrap;
      rise_q <= wrap && (phase_q == PH_W'(HALF - 1));
      fall_q <= period_end;
      if (wrap) begin
        phase_q  <= phase_nxt;
        scl_hi_q <= (phase_nxt >= PH_W'(HALF));
      end
    end
  end
endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
  import scl_div_pkg::*;
#(
  parameter logic [BAUD_W-1:0] RESET_BAUD   = 7'h44,
  parameter bit                EXP_PLUS_ONE = 1'b1,
  parameter int                PHASES       = 10,
  localparam int               PH_W         = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_en,
  input  logic              baud_wr,
  input  logic [BAUD_W-1:0] baud_wdata,
  output logic [BAUD_W-1:0] baud_rd,
  output logic              bit_tick,
  output logic [PH_W-1:0]   phase_idx,
  output logic              scl_high,
  output logic              scl_rise,
  output logic              scl_fall
);
  baud_t reg_q;
  baud_t act_q;
  logic  wrap;
  logic  period_end;

  scl_baud_reg #(.RESET_BAUD(RESET_BAUD)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .en         (eng_en),
    .wr_en      (baud_wr),
    .wr_data    (baud_t'(baud_wdata)),
    .period_end (period_end),
    .baud_q     (reg_q),
    .act_q      (act_q)
  );

  scl_prescaler #(.EXP_PLUS_ONE(EXP_PLUS_ONE)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (eng_en),
    .act  (act_q),
    .wrap (wrap)
  );

  scl_phase_seq #(.PHASES(PHASES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (eng_en),
    .wrap       (wrap),
    .period_end (period_end),
    .tick_q     (bit_tick),
    .phase_q    (phase_idx),
    .scl_hi_q   (scl_high),
    .rise_q     (scl_rise),
    .fall_q     (scl_fall)
  );

  assign baud_rd = reg_q;
endmodule

// File: rtl/scl_rate_div_chk.sv
module scl_rate_div_chk (
  input logic       clk,
  input logic       rst,
  input logic       eng_en,
  input logic       baud_wr,
  input logic [6:0] baud_wdata,
  input logic [6:0] baud_rd,
  input logic       bit_tick,
  input logic [3:0] phase_idx,
  input logic       scl_high,
  input logic       scl_rise,
  input logic       scl_fall
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    baud_wr |=> (baud_rd == $past(baud_wdata)));                       // R2
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase_idx <= 4'd9);                                                // R4
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (eng_en && $past(eng_en) && !bit_tick) |-> $stable(phase_idx));    // R4
  AST_RISE_AT_HALF: assert property (@(posedge clk) disable iff (rst)
    scl_rise |-> (bit_tick && phase_idx == 4'd5 && scl_high));         // R5
  AST_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    scl_fall |-> (bit_tick && phase_idx == 4'd0 && !scl_high));        // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !eng_en |=> (!bit_tick && !scl_rise && !scl_fall && phase_idx == 4'd0)); // R7
endmodule

bind scl_rate_div scl_rate_div_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .eng_en     (eng_en),
  .baud_wr    (baud_wr),
  .baud_wdata (baud_wdata),
  .baud_rd    (baud_rd),
  .bit_tick   (bit_tick),
  .phase_idx  (phase_idx),
  .scl_high   (scl_high),
  .scl_rise   (scl_rise),
  .scl_fall   (scl_fall)
);

// File: tb/scl_rate_div_tb.sv
module scl_rate_div_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       eng_en = 1'b0;
  logic       baud_wr = 1'b0;
  logic [6:0] baud_wdata = '0;
  logic [6:0] baud_rd, baud_rd_v;
  logic       bit_tick, bit_tick_v;
  logic [3:0] phase_idx, phase_idx_v;
  logic       scl_high, scl_high_v, scl_rise, scl_rise_v, scl_fall, scl_fall_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_rate_div u_dut (
    .clk(clk), .rst(rst), .eng_en(eng_en), .baud_wr(baud_wr),
    .baud_wdata(baud_wdata), .baud_rd(baud_rd), .bit_tick(bit_tick),
    .phase_idx(phase_idx), .scl_high(scl_high), .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  scl_rate_div #(.EXP_PLUS_ONE(1'b0)) u_dut_v (
    .clk(clk), .rst(rst), .eng_en(eng_en), .baud_wr(baud_wr),
    .baud_wdata(baud_wdata), .baud_rd(baud_rd_v), .bit_tick(bit_tick_v),
    .phase_idx(phase_idx_v), .scl_high(scl_high_v), .scl_rise(scl_rise_v),
    .scl_fall(scl_fall_v)
  );

  function automatic int phase_len(logic [6:0] b, bit plus1);
    return (int'(b[6:3]) + 1) * (1 << (int'(b[2:0]) + (plus1 ? 1 : 0)));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until the selected tick is seen high
  task automatic wait_tick(bit alt, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(alt ? bit_tick_v : bit_tick) && n < 10000);
  endtask

  task automatic write_baud(logic [6:0] b);
    baud_wr = 1'b1;
    baud_wdata = b;
    @(negedge clk);
    baud_wr = 1'b0;
  endtask

  // full SCL period check on the default-mode instance
  task automatic run_period(logic [6:0] b);
    int n;
    int p;
    p = phase_len(b, 1'b1);
    for (int k = 1; k <= 10; k++) begin
      wait_tick(1'b0, n);
      chk(n == p, "R3 tick spacing", n, p);
      chk(phase_idx == 4'(k % 10), "R4 phase order", phase_idx, k % 10);
      chk(scl_high == ((k % 10) >= 5), "R5 scl level", scl_high, (k % 10) >= 5);
      chk(scl_rise == (k == 5), "R5 rise pulse", scl_rise, k == 5);
      chk(scl_fall == (k == 10), "R5 fall pulse", scl_fall, k == 10);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [6:0] b;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(baud_rd == 7'h44, "R1 reset baud", baud_rd, 'h44);
    chk(!bit_tick && !scl_high && !scl_rise && !scl_fall, "R1 outputs low",
        {bit_tick, scl_high, scl_rise, scl_fall}, 0);
    chk(phase_idx == 0, "R1 phase", phase_idx, 0);

    // R3 default divider from reset value: 9*32 = 288
    eng_en = 1'b1;
    wait_tick(1'b0, n);
    chk(n == 288, "R3 reset divider first tick", n, 288);
    wait_tick(1'b0, n);
    chk(n == 288, "R3 reset divider spacing", n, 288);

    // R7 disabled: quiet and held at zero
    eng_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      chk(!bit_tick && !scl_rise && !scl_fall, "R7 no pulses when off",
          {bit_tick, scl_rise, scl_fall}, 0);
      chk(phase_idx == 0 && !scl_high, "R7 phase held", phase_idx, 0);
      @(negedge clk);
    end

    // randomized rate values, written while disabled (R2, R8)
    for (int it = 0; it < 8; it++) begin
      b = {4'($urandom % 16), 3'($urandom % 4)};
      write_baud(b);
      chk(baud_rd == b, "R2 readback", baud_rd, b);
      eng_en = 1'b1;
      run_period(b);                                     // R8 via first tick
      eng_en = 1'b0;
      @(negedge clk);
      eng_en = 1'b1;
      wait_tick(1'b1, n);
      chk(n == phase_len(b, 1'b0), "R9 variant spacing", n, phase_len(b, 1'b0));
      eng_en = 1'b0;
      @(negedge clk);
    end

    // R10 extremes, both modes
    write_baud(7'h00);
    eng_en = 1'b1;
    run_period(7'h00);
    eng_en = 1'b0;
    @(negedge clk);
    eng_en = 1'b1;
    wait_tick(1'b1, n);
    chk(n == 1, "R10 min variant", n, 1);
    eng_en = 1'b0;
    write_baud(7'h7F);
    eng_en = 1'b1;
    wait_tick(1'b0, n);
    chk(n == 4096, "R10 max divider", n, 4096);
    eng_en = 1'b0;
    @(negedge clk);
    eng_en = 1'b1;
    wait_tick(1'b1, n);
    chk(n == 2048, "R10 max variant", n, 2048);
    eng_en = 1'b0;

    // R6 change mid-period: 0x08 (4 cycles) then 0x10 (6 cycles)
    write_baud(7'h08);
    eng_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_tick(1'b0, n);
      chk(n == 4, "R6 old spacing before write", n, 4);
    end
    baud_wr = 1'b1;
    baud_wdata = 7'h10;
    @(negedge clk);
    baud_wr = 1'b0;
    chk(baud_rd == 7'h10, "R2 readback while running", baud_rd, 'h10);
    wait_tick(1'b0, n);
    chk(n + 1 == 4, "R6 old spacing after write", n + 1, 4);
    for (int k = 5; k <= 10; k++) begin
      wait_tick(1'b0, n);
      chk(n == 4, "R6 old spacing to period end", n, 4);
    end
    chk(phase_idx == 0, "R6 period end reached", phase_idx, 0);
    for (int k = 0; k < 3; k++) begin
      wait_tick(1'b0, n);
      chk(n == 6, "R6 new spacing", n, 6);
    end

    // R7 re-enable restarts counting from zero
    eng_en = 1'b0;
    repeat (3) @(negedge clk);
    eng_en = 1'b1;
    wait_tick(1'b0, n);
    chk(n == 6, "R7 restart after re-enable", n, 6);
    chk(phase_idx == 1, "R7 phase restarts", phase_idx, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule